// File: doc/BRIEF.md
# Multiplexed-bus opcode fetch sequencer

This block runs a single four-clock opcode fetch on a bus whose low address byte and data byte share one set of lines. A one-cycle start request, accepted only while the block is idle, loads a 16-bit fetch address. The block then steps through four clocks. In the first it drives the whole address, with the high byte on dedicated lines and the low byte on the shared lines, while the latch enable is high. In the second and third it releases the shared lines and asserts the read strobe so the memory can answer. In the fourth it ends the read and presents the captured opcode byte to the decoder for one cycle.

A transparent latch inside the block, opened by the latch enable, keeps the low address byte so that the full address stays valid after the shared lines turn to data. The shared lines are modelled as three signals: a driven value, an output enable and the resolved pin value. The surrounding logic merges them into a real bidirectional pad. The write strobe is held inactive because this block only reads.

Top module: `fetch_seq`

## Requirements
- R1: After reset, and whenever no fetch is running, ale_o=1, rd_no=1, wr_no=1, ad_oe_o=0 and opcode_valid_o=0.
- R2: A start_i sampled high at a clock edge while idle makes the next clock fetch clock 1. In that clock ale_o=1, rd_no=1, wr_no=1, ad_oe_o=1, ad_o equals fetch address bits 7:0 and addr_hi_o equals bits 15:8.
- R3: Fetch clock 2 follows clock 1, with ale_o=0, rd_no=0, wr_no=1 and ad_oe_o=0.
- R4: Fetch clock 3 follows clock 2, with ale_o=0, rd_no=0, wr_no=1 and ad_oe_o=0.
- R5: Fetch clock 4 follows clock 3, with ale_o=0, rd_no=1, wr_no=1 and ad_oe_o=0. opcode_valid_o is 1 for exactly this one clock, and opcode_o equals the ad_i value present during clock 3.
- R6: lat_addr_o bits 7:0 follow ad_o while ale_o=1 and hold while ale_o=0. Bits 15:8 equal addr_hi_o, so lat_addr_o equals the fetch address from clock 1 through clock 4.
- R7: A start_i sampled during clocks 1 to 4 has no effect. The fetch under way completes unchanged and the block then returns to idle.
- R8: opcode_o holds its value from one capture to the next.
- R9: A start_i sampled in the idle cycle right after clock 4 begins a new fetch. A fetch from address 2005h of a memory holding 4Fh there gives opcode_o=4Fh.
- R10: wr_no stays 1 in every cycle.
- R11: rst_ni low during a fetch ends it at once and restores the idle outputs of R1, with opcode_o=0 and lat_addr_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Fetch request, sampled while idle |
| fetch_addr_i | input | 16 | Address to fetch from |
| ale_o | output | 1 | Address latch enable, high opens the latch |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low, held high |
| addr_hi_o | output | 8 | Dedicated high address lines |
| ad_o | output | 8 | Value driven on the shared lines |
| ad_oe_o | output | 1 | Drive enable of the shared lines |
| ad_i | input | 8 | Resolved value of the shared lines |
| lat_addr_o | output | 16 | Demultiplexed address: high lines and latched low byte |
| opcode_o | output | 8 | Captured opcode byte |
| opcode_valid_o | output | 1 | One-cycle strobe marking a new opcode |

## Verification
The assertions check the strobe sequence on every cycle. The shared lines are never driven while the read strobe is low, and driving happens only with the latch enable high. The read strobe stays low for two clocks once it falls and its rise coincides with the single valid pulse. The captured byte equals the pin value of the cycle before, the latched address and the opcode hold between their update points, and no fetch begins in the clock after the read ends. Other properties can be shown only by the bench's scenarios, which compare every cycle against a behavioural model. These include the correct address reaching a memory that answers through the latch, the dropping of starts during a fetch, back-to-back fetches, the fixed 2005h to 4Fh case and a reset in the middle of a read.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } fetch_st_e;

  typedef struct packed {
    logic ale;
    logic rd_n;
    logic wr_n;
    logic ad_oe;
  } bus_ctrl_t;

  localparam bus_ctrl_t CTRL_IDLE = '{ale: 1'b1, rd_n: 1'b1, wr_n: 1'b1, ad_oe: 1'b0};

  function automatic bus_ctrl_t ctrl_of(fetch_st_e s);
    bus_ctrl_t c;
    c = CTRL_IDLE;
    case (s)
      ST_T1: c = '{ale: 1'b1, rd_n: 1'b1, wr_n: 1'b1, ad_oe: 1'b1};
      ST_T2: c = '{ale: 1'b0, rd_n: 1'b0, wr_n: 1'b1, ad_oe: 1'b0};
      ST_T3: c = '{ale: 1'b0, rd_n: 1'b0, wr_n: 1'b1, ad_oe: 1'b0};
      ST_T4: c = '{ale: 1'b0, rd_n: 1'b1, wr_n: 1'b1, ad_oe: 1'b0};
      default: c = CTRL_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fetch_seq_fsm.sv
module fetch_seq_fsm
  import fetch_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  output fetch_st_e state_o,
  output bus_ctrl_t ctrl_o,
  output logic      load_o
);

  fetch_st_e state_q, state_d;
  bus_ctrl_t ctrl_q;

  assign load_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ST_T4;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // controls registered from the next state: clean pins, same timing as state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctrl_q  <= CTRL_IDLE;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_of(state_d);
    end
  end

  assign state_o = state_q;
  assign ctrl_o  = ctrl_q;

endmodule

// File: rtl/fetch_seq_latch.sv
module fetch_seq_latch #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q_bit;
    always_latch begin
      if (!rst_ni)   q_bit = 1'b0;
      else if (le_i) q_bit = d_i[b];
    end
    assign q_o[b] = q_bit;
  end

endmodule

// File: rtl/fetch_seq_datapath.sv
module fetch_seq_datapath
  import fetch_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  fetch_st_e         state_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] addr_lo_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic              opcode_valid_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opc_q;
  logic              vld_q;
  logic              cap_en;

  // sample on the edge that closes clock 3, before the read strobe rises
  assign cap_en = (state_i == ST_T3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= cap_en;
      if (cap_en) opc_q <= ad_i;
    end
  end

  assign addr_hi_o      = addr_q[ADDR_W-1:DATA_W];
  assign addr_lo_o      = addr_q[DATA_W-1:0];
  assign opcode_o       = opc_q;
  assign opcode_valid_o = vld_q;

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic              opcode_valid_o
);

  fetch_st_e         state;
  bus_ctrl_t         ctrl;
  logic              load;
  logic [DATA_W-1:0] addr_lo;
  logic [DATA_W-1:0] lat_lo;

  fetch_seq_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state),
    .ctrl_o  (ctrl),
    .load_o  (load)
  );

  fetch_seq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_i         (load),
    .addr_i         (fetch_addr_i),
    .state_i        (state),
    .ad_i           (ad_i),
    .addr_hi_o      (addr_hi_o),
    .addr_lo_o      (addr_lo),
    .opcode_o       (opcode_o),
    .opcode_valid_o (opcode_valid_o)
  );

  // fed from the held address register, so the latch cannot race the bus turnaround
  fetch_seq_latch #(
    .W (DATA_W)
  ) u_lat (
    .rst_ni (rst_ni),
    .le_i   (ctrl.ale),
    .d_i    (addr_lo),
    .q_o    (lat_lo)
  );

  assign ale_o      = ctrl.ale;
  assign rd_no      = ctrl.rd_n;
  assign wr_no      = ctrl.wr_n;
  assign ad_oe_o    = ctrl.ad_oe;
  assign ad_o       = addr_lo;
  assign lat_addr_o = {addr_hi_o, lat_lo};

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ale_o,
  input logic              rd_no,
  input logic              ad_oe_o,
  input logic [DATA_W-1:0] ad_i,
  input logic [ADDR_W-1:0] lat_addr_o,
  input logic [DATA_W-1:0] opcode_o,
  input logic              opcode_valid_o
);

  a_r3_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);

  a_r2_drive_with_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> ale_o);

  a_r3_ale_fall_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> !rd_no);

  a_r4_read_two_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |=> !rd_no);

  a_r5_valid_on_rd_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_no) |-> opcode_valid_o);

  a_r5_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_valid_o |=> !opcode_valid_o);

  a_r5_capture_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_valid_o |-> opcode_o == $past(ad_i));

  a_r6_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_o && $past(!ale_o)) |-> $stable(lat_addr_o));

  a_r8_opcode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opcode_valid_o |-> $stable(opcode_o));

  a_r7_no_start_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_no) |=> !ad_oe_o);

endmodule

bind fetch_seq fetch_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ale_o          (ale_o),
  .rd_no          (rd_no),
  .ad_oe_o        (ad_oe_o),
  .ad_i           (ad_i),
  .lat_addr_o     (lat_addr_o),
  .opcode_o       (opcode_o),
  .opcode_valid_o (opcode_valid_o)
);

// File: tb/fetch_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic        ale_o, rd_no, wr_no, ad_oe_o, opcode_valid_o;
  logic [7:0]  addr_hi_o, ad_o, ad_bus, opcode_o;
  logic [15:0] lat_addr_o;

  int checks = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  // behavioural memory, answers only while the read strobe is low
  function automatic logic [7:0] mem_rd(logic [15:0] a);
    if (a == 16'h2005) return 8'h4F;
    return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'hA5;
  endfunction

  assign ad_bus = ad_oe_o ? ad_o : (!rd_no ? mem_rd(lat_addr_o) : 8'hFF);

  fetch_seq dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .fetch_addr_i   (fetch_addr_i),
    .ale_o          (ale_o),
    .rd_no          (rd_no),
    .wr_no          (wr_no),
    .addr_hi_o      (addr_hi_o),
    .ad_o           (ad_o),
    .ad_oe_o        (ad_oe_o),
    .ad_i           (ad_bus),
    .lat_addr_o     (lat_addr_o),
    .opcode_o       (opcode_o),
    .opcode_valid_o (opcode_valid_o)
  );

  // reference model: phase 0 idle, 1..4 fetch clocks
  int          phase = 0;
  logic [15:0] ref_addr = '0;
  logic [7:0]  ref_opc = '0;
  bit          rst_tag = 1'b0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase = 0; ref_addr = '0; ref_opc = '0;
    end else begin
      case (phase)
        0: if (start_i) begin phase = 1; ref_addr = fetch_addr_i; end
        3: begin phase = 4; ref_opc = mem_rd(ref_addr); end
        4: phase = 0;
        default: phase = phase + 1;
      endcase
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h phase=%0d t=%0t", req, act, exp, phase, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [4:0] exp_c;
    string      tag;
    case (phase)
      1: begin exp_c = 5'b11110; tag = "R2"; end
      2: begin exp_c = 5'b00100; tag = "R3"; end
      3: begin exp_c = 5'b00100; tag = "R4"; end
      4: begin exp_c = 5'b01101; tag = "R5"; end
      default: begin exp_c = 5'b11100; tag = rst_tag ? "R11" : (start_i ? "R7" : "R1"); end
    endcase
    chk(tag, {27'd0, ale_o, rd_no, wr_no, ad_oe_o, opcode_valid_o}, {27'd0, exp_c});
    chk("R10", {31'd0, wr_no}, 32'd1);
    chk("R6", {16'd0, lat_addr_o}, {16'd0, ref_addr});
    chk("R2", {16'd0, addr_hi_o, ad_o}, {16'd0, ref_addr});
    chk("R8", {24'd0, opcode_o}, {24'd0, ref_opc});
    if (phase == 4 && ref_addr == 16'h2005) chk("R9", {24'd0, opcode_o}, 32'h4F);
  end

  task automatic fetch(logic [15:0] a, int gap);
    @(negedge clk); #1 start_i = 1'b1; fetch_addr_i = a;
    @(negedge clk); #1 start_i = 1'b0; fetch_addr_i = ~a;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    fetch(16'h2005, 5);
    fetch(16'h0000, 4);
    fetch(16'hFFFF, 6);
    fetch(16'h12AB, 5);
    fetch(16'h80FE, 4);
    // R9 back-to-back: start right at the idle cycle after clock 4
    fetch(16'h3C5A, 3);
    fetch(16'h2005, 4);
    // R7 start held high with changing address across several fetches
    for (int i = 0; i < 14; i++) begin
      @(negedge clk); #1 start_i = 1'b1; fetch_addr_i = 16'h4000 + 16'(i * 16'h0123);
    end
    @(negedge clk); #1 start_i = 1'b0;
    repeat (6) @(negedge clk);
    // R11 reset in the middle of a read
    fetch(16'hBEEF, 1);
    #1 rst_ni = 1'b0; rst_tag = 1'b1;
    @(negedge clk); @(negedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk); #1 rst_tag = 1'b0;
    fetch(16'h7E01, 6);
    fetch(16'h2005, 6);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule